// File: doc/BRIEF.md
# Dual-Mode Host Bus Slave Port

This block sits between a host processor bus and a small bank of 32-bit registers. A static mode pin chooses between two handshake styles. In strobe/acknowledge style the host waits for an active-low acknowledge. In wait-handshake style the slave pulls an active-low wait line down during the access and lets it go high to mark completion. In both styles two active-low size pins pick the byte lanes that a write touches.

An access opens when chip select and data strobe are both low. Both pass through two-flop synchronizers. The block then captures address, direction, lane pins and write data. After a fixed two-cycle internal latency it completes the access: it either updates the register file or returns a full word on the read data bus. An address beyond the register bank raises a bus error. In strobe/acknowledge style the error replaces the acknowledge. In wait-handshake style the acknowledge is still given. Every handshake output has its own output enable, which is high only while an access is open, so the pads can be released between accesses. After completion the block holds its result until chip select or data strobe goes high again.

The port uses plain bus handshake pins and does not use a valid/ready stream. Back-pressure is given only by holding off the acknowledge or the wait release.

Top module: `hbus_slave`

## Requirements
- R1: After reset, ack_n, wait_n and berr_n are high, and ack_oe, wait_oe, berr_oe and rdata_oe are low.
- R2: An access starts only when cs_n and ds_n are both low. Either one low alone leaves every output enable low.
- R3: With cs_n and ds_n driven low before clock edge 1, ack_oe is high and ack_n is still high after edge 4. The completion result appears after edge 5.
- R4: With bus_mode=0 (strobe/acknowledge) and a valid address, ack_n goes low at completion, and wait_oe stays low for the whole access.
- R5: With bus_mode=1 (wait-handshake), wait_oe is high and wait_n is low while the access is pending. wait_n goes high at completion, and ack_n goes low at the same time.
- R6: An address of NREG or more drives berr_n low at completion. With bus_mode=0, ack_n then stays high.
- R7: With bus_mode=1, an invalid address still drives ack_n low at completion, together with berr_n low.
- R8: Lane selection on a write uses sz_n, with each bit active low. sz_n[0]=0 writes bits 7:0. sz_n[1]=0 writes bits 15:8. Bits 31:16 are written only when both sz_n bits are 0. sz_n=2'b11 writes nothing.
- R9: A read (rd_wr=1) of a valid address shows the full stored word on rdata with rdata_oe high at completion. An invalid read keeps rdata_oe low. A write to an invalid address changes no register.
- R10: After completion the result is held while cs_n and ds_n stay low. Raising either one releases all output enables after the third following clock edge.
- R11: ack_oe and berr_oe are high exactly while an access is open. wait_oe is high only during accesses made with bus_mode=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | 0 = strobe/acknowledge, 1 = wait-handshake |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rd_wr | input | 1 | 1 = read, 0 = write |
| sz_n | input | 2 | Active-low lane selects (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | Read data drive enable |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_oe | output | 1 | Acknowledge drive enable |
| wait_n | output | 1 | Wait, active low, rises at completion |
| wait_oe | output | 1 | Wait drive enable |
| berr_n | output | 1 | Bus error, active low |
| berr_oe | output | 1 | Bus error drive enable |

## Verification
A strobe pair driven low just before a clock edge reaches the control logic after two edges. The access opens on the third edge, and its result is due on the fifth. Release is seen three edges after a strobe rises. The bench drives inputs on falling edges and counts rising edges from that point. It samples the pending state after edge 4, the completion state after edge 5, and the idle state after the third edge past release. The hold test also samples after the second edge past release, where the enables must still be high.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    HB_IDLE = 2'd0,
    HB_WORK = 2'd1,
    HB_DONE = 2'd2
  } hb_state_e;

  localparam logic MODE_STROBE = 1'b0;
  localparam logic MODE_WAIT   = 1'b1;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      dout <= '1;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NREG    = 8,
  parameter int ACC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              mode_in,
  input  logic              rd_in,
  input  logic [1:0]        sz_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              active,
  output logic              done,
  output logic              commit,
  output logic              mode_q,
  output logic              rd_q,
  output logic              valid_q,
  output logic [1:0]        sz_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_LAT - 1);
  localparam logic [ADDR_W:0]  ADDR_LIM = (ADDR_W+1)'(NREG);

  hb_state_e        state;
  logic [CNT_W-1:0] cnt;

  assign active = (state != HB_IDLE);
  assign done   = (state == HB_DONE);
  assign commit = (state == HB_WORK) && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= HB_IDLE;
      cnt     <= '0;
      mode_q  <= MODE_STROBE;
      rd_q    <= 1'b0;
      valid_q <= 1'b0;
      sz_q    <= '1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        HB_IDLE: if (sel) begin
          state   <= HB_WORK;
          cnt     <= '0;
          mode_q  <= mode_in;
          rd_q    <= rd_in;
          sz_q    <= sz_in;
          addr_q  <= addr_in;
          wdata_q <= wdata_in;
          valid_q <= ({1'b0, addr_in} < ADDR_LIM);
        end
        HB_WORK: begin
          if (cnt == CNT_LAST) state <= HB_DONE;
          else                 cnt   <= cnt + 1'b1;
        end
        HB_DONE: if (!sel) state <= HB_IDLE;
        default: state <= HB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NREG   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] lane_mask,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[g][b*8 +: 8] <= '0;
        else if (we && lane_mask[b] && (addr == ADDR_W'(g)))
          regs[g][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == ADDR_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NREG    = 8,
  parameter int ACC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mode,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic              rd_wr,
  input  logic [1:0]        sz_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              ack_n,
  output logic              ack_oe,
  output logic              wait_n,
  output logic              wait_oe,
  output logic              berr_n,
  output logic              berr_oe
);
  localparam int LANES = DATA_W / 8;

  logic [1:0]        strb_s;
  logic              sel;
  logic              active, done, commit, mode_q, rd_q, valid_q;
  logic [1:0]        sz_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rf_rdata, rdata_q;
  logic [LANES-1:0]  lane_mask;

  hbus_sync #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, ds_n}),
    .dout (strb_s)
  );

  assign sel = (strb_s == 2'b00);

  hbus_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .ACC_LAT(ACC_LAT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .mode_in (bus_mode),
    .rd_in   (rd_wr),
    .sz_in   (sz_n),
    .addr_in (addr),
    .wdata_in(wdata),
    .active  (active),
    .done    (done),
    .commit  (commit),
    .mode_q  (mode_q),
    .rd_q    (rd_q),
    .valid_q (valid_q),
    .sz_q    (sz_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q)
  );

  // Lanes 0 and 1 follow their own select; the upper lanes need both.
  for (genvar b = 0; b < LANES; b++) begin : g_mask
    if (b < 2) begin : g_low
      assign lane_mask[b] = !sz_q[b];
    end else begin : g_high
      assign lane_mask[b] = (sz_q == 2'b00);
    end
  end

  hbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (commit && !rd_q && valid_q),
    .addr     (addr_q),
    .lane_mask(lane_mask),
    .wdata    (wdata_q),
    .rdata    (rf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        rdata_q <= '0;
    else if (commit && rd_q && valid_q) rdata_q <= rf_rdata;
  end

  assign rdata    = rdata_q;
  assign rdata_oe = done && rd_q && valid_q;
  assign ack_oe   = active;
  assign ack_n    = !(done && ((mode_q == MODE_WAIT) || valid_q));
  assign wait_oe  = active && (mode_q == MODE_WAIT);
  assign wait_n   = !(wait_oe && !done);
  assign berr_oe  = active;
  assign berr_n   = !(done && !valid_q);
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ack_n,
  input logic ack_oe,
  input logic wait_n,
  input logic wait_oe,
  input logic berr_n,
  input logic berr_oe,
  input logic rdata_oe
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_oe |-> (ack_n && berr_n && wait_n && !rdata_oe));

  p_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |=> (ack_oe && ack_n));

  p_wait_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_oe && $rose(wait_n)) |-> !ack_n);

  p_berr_blocks_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_oe && !berr_n && !wait_oe) |-> ack_n);

  p_berr_keeps_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_oe && !berr_n && wait_oe) |-> !ack_n);

  p_rdata_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (ack_oe && berr_n));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && !ack_n) |=> (!ack_n || !ack_oe));

  p_oe_group_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe == berr_oe) && (!wait_oe || ack_oe));
endmodule

bind hbus_slave hbus_slave_chk u_chk (.*);

// File: tb/hbus_slave_bench.sv
module hbus_slave_bench;
  typedef struct packed {
    logic        mode;
    logic        rd;
    logic [3:0]  addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic        e_ack;
    logic        e_berr;
    logic [31:0] e_rd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd1, 2'b00, 32'h11223344, 1'b0, 1'b1, 32'h0},         // R4 R8 full word
    '{1'b0, 1'b1, 4'd1, 2'b00, 32'h0,        1'b0, 1'b1, 32'h11223344},  // R9
    '{1'b1, 1'b0, 4'd1, 2'b10, 32'hAABBCCDD, 1'b0, 1'b1, 32'h0},         // R8 lane 0
    '{1'b1, 1'b1, 4'd1, 2'b00, 32'h0,        1'b0, 1'b1, 32'h112233DD},
    '{1'b0, 1'b0, 4'd1, 2'b01, 32'h0000EE00, 1'b0, 1'b1, 32'h0},         // R8 lane 1
    '{1'b0, 1'b1, 4'd1, 2'b00, 32'h0,        1'b0, 1'b1, 32'h1122EEDD},
    '{1'b0, 1'b0, 4'd9, 2'b00, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h0},         // R6
    '{1'b1, 1'b0, 4'd9, 2'b00, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0},         // R7
    '{1'b1, 1'b1, 4'd9, 2'b00, 32'h0,        1'b0, 1'b0, 32'h0},         // R7 R9
    '{1'b0, 1'b0, 4'd7, 2'b00, 32'h5A5AA5A5, 1'b0, 1'b1, 32'h0},
    '{1'b1, 1'b1, 4'd7, 2'b00, 32'h0,        1'b0, 1'b1, 32'h5A5AA5A5},
    '{1'b0, 1'b1, 4'd0, 2'b00, 32'h0,        1'b0, 1'b1, 32'h0},
    '{1'b0, 1'b0, 4'd1, 2'b11, 32'h0,        1'b0, 1'b1, 32'h0},         // R8 no lane
    '{1'b1, 1'b1, 4'd1, 2'b00, 32'h0,        1'b0, 1'b1, 32'h1122EEDD}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_mode = 1'b0, cs_n = 1'b1, ds_n = 1'b1, rd_wr = 1'b1;
  logic [1:0]  sz_n = 2'b11;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdata_oe, ack_n, ack_oe, wait_n, wait_oe, berr_n, berr_oe;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  hbus_slave u_hbus_slave (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(req, {28'd0, ack_oe, berr_oe, wait_oe, rdata_oe}, 32'h0);
    chk(req, {29'd0, ack_n, berr_n, wait_n}, 32'h7);
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    bus_mode = v.mode; rd_wr = v.rd; addr = v.addr; sz_n = v.sz; wdata = v.wd;
    cs_n = 1'b0; ds_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3 pending ack_oe/ack_n", {30'd0, ack_oe, ack_n}, 32'h3);
    chk("R11 wait_oe follows mode", {31'd0, wait_oe}, {31'd0, v.mode});
    if (v.mode) chk("R5 wait_n low while pending", {31'd0, wait_n}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R4/R6/R7 ack_n at completion", {31'd0, ack_n}, {31'd0, v.e_ack});
    chk("R6/R7 berr_n at completion", {31'd0, berr_n}, {31'd0, v.e_berr});
    if (v.mode) chk("R5 wait_n released", {31'd0, wait_n}, 32'h1);
    if (v.rd) begin
      chk("R9 rdata_oe", {31'd0, rdata_oe}, {31'd0, v.e_berr});
      if (v.e_berr) chk("R9 R8 read word", rdata, v.e_rd);
    end
    cs_n = 1'b1; ds_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_chk("R10 R11 idle after release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 reset state");
    rst_n = 1'b1;

    foreach (VECS[i]) run_vec(VECS[i]);

    // R2: one strobe alone never opens an access
    @(negedge clk);
    cs_n = 1'b0; ds_n = 1'b1;
    repeat (8) @(negedge clk);
    idle_chk("R2 cs_n alone");
    cs_n = 1'b1; ds_n = 1'b0;
    repeat (8) @(negedge clk);
    idle_chk("R2 ds_n alone");
    ds_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: hold result while strobes stay low, release on ds_n alone
    bus_mode = 1'b0; rd_wr = 1'b1; addr = 4'd7; sz_n = 2'b00;
    cs_n = 1'b0; ds_n = 1'b0;
    repeat (5) @(posedge clk);
    repeat (7) @(negedge clk);
    chk("R10 ack held while strobes low", {30'd0, ack_oe, ack_n}, 32'h2);
    chk("R10 read word held", rdata, 32'h5A5AA5A5);
    ds_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 still held two edges after release", {30'd0, ack_oe, ack_n}, 32'h2);
    @(posedge clk);
    @(negedge clk);
    idle_chk("R10 released on third edge");
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset in the middle of an access clears everything
    cs_n = 1'b0; ds_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1'b1; ds_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 reset mid-access");
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule